// File: doc/BRIEF.md
# SHA-1 Block Compression Engine

This block runs the SHA-1 compression function on a single 512-bit message block and folds the result into a 160-bit chaining digest. It works iteratively and does one round per clock. The host gives it blocks that are already padded. A start strobe opens a new message from the standard initial hash words. A continue strobe hashes one more block of the same message, taking the current digest as the chaining value.

A command is accepted only while the engine is idle. On the accepting edge the block input is copied into a 16-word sliding schedule window. One setup cycle then loads the working words from the chaining digest. Eighty round cycles follow, and each one consumes one schedule word through an advance handshake. A final cycle adds the working words into the digest. A block therefore takes 82 cycles from its command to its result. Strobes that arrive while the engine is busy are dropped.

Top module: `sha1_engine`

## Requirements
- R1: After reset, ready_o is 1, digest_valid_o is 0 and digest_o is all zeros.
- R2: A start command (init_i) loads the chaining words with 67452301, EFCDAB89, 98BADCFE, 10325476 and C3D2E1F0 (hex). It then compresses the block using the standard SHA-1 round functions and constants, so digest_o equals the SHA-1 compression of the block from those words.
- R3: A continue command (next_i) compresses the block using the current digest_o as the chaining value. Multi-block messages therefore chain correctly, including a continue issued directly after reset (chaining value zero).
- R4: ready_o goes high again exactly 82 rising edges after the edge that accepted the command, and the schedule advances only while the engine is busy.
- R5: On the accepting edge ready_o and digest_valid_o both fall.
- R6: A strobe that arrives while ready_o is 0 is ignored: digest_o holds its value during the busy period, and the pending result is unchanged.
- R7: If init_i and next_i are both high on an accepting edge, the start command wins.
- R8: block_i is sampled only on the accepting edge. Changes during processing have no effect.
- R9: digest_valid_o rises together with ready_o at the end of a block. It implies ready_o and stays high until the next accepted command.
- R10: Schedule word 0 is block_i[511:480] (big-endian word order), and digest_o[159:128] holds the first chaining word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Start a new message with this block |
| next_i | input | 1 | Continue the message with this block |
| block_i | input | 512 | Padded message block, word 0 in the top bits |
| ready_o | output | 1 | Engine idle, commands accepted |
| digest_o | output | 160 | Chaining digest, first word in the top bits |
| digest_valid_o | output | 1 | digest_o holds a completed result |

## Verification
The hardest cases to reach are a strobe that lands in the middle of the 82-cycle busy window and a block input that changes after it has been captured. Neither case shows up at the ports unless the final digest differs. The driver therefore issues start and continue strobes at chosen points inside the busy window, and after every accepted command it overwrites block_i with unrelated data. The scoreboard expects the digest of the originally accepted block only. The bench also covers a continue issued straight from reset and both strobes raised together. These are the two cases where the choice of chaining value alone sets the answer.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
  localparam int WORD_W   = 32;
  localparam int WIN      = 16;
  localparam int BLOCK_W  = WORD_W * WIN;
  localparam int NWORDS   = 5;
  localparam int DIGEST_W = WORD_W * NWORDS;
  localparam int ROUNDS   = 80;
  localparam int STAGE    = ROUNDS / 4;
  localparam int CNT_W    = $clog2(ROUNDS);

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
  } work_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ROUND = 2'd2,
    ST_FINAL = 2'd3
  } state_e;

  localparam work_t IV = '{
    a: 32'h67452301,
    b: 32'hEFCDAB89,
    c: 32'h98BADCFE,
    d: 32'h10325476,
    e: 32'hC3D2E1F0
  };

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic work_t add_work(input work_t x, input work_t y);
    work_t r;
    r.a = x.a + y.a;
    r.b = x.b + y.b;
    r.c = x.c + y.c;
    r.d = x.d + y.d;
    r.e = x.e + y.e;
    return r;
  endfunction
endpackage

// File: rtl/sha1_wsched.sv
module sha1_wsched
  import sha1_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               adv_i,
  input  logic [BLOCK_W-1:0] block_i,
  output word_t              w_o
);
  localparam int TAP_3  = WIN - 3;
  localparam int TAP_8  = WIN - 8;
  localparam int TAP_14 = WIN - 14;

  word_t win_q [WIN];
  word_t new_w;

  assign new_w = rotl(win_q[TAP_3] ^ win_q[TAP_8] ^ win_q[TAP_14] ^ win_q[0], 1);
  assign w_o   = win_q[0];

  for (genvar gi = 0; gi < WIN; gi++) begin : g_win
    word_t shift_in;
    if (gi == WIN - 1) begin : g_top
      assign shift_in = new_w;
    end else begin : g_mid
      assign shift_in = win_q[gi+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     win_q[gi] <= '0;
      else if (load_i) win_q[gi] <= block_i[(WIN-1-gi)*WORD_W +: WORD_W];
      else if (adv_i)  win_q[gi] <= shift_in;
    end
  end
endmodule

// File: rtl/sha1_round.sv
module sha1_round
  import sha1_pkg::*;
(
  input  logic [CNT_W-1:0] round_i,
  input  work_t            st_i,
  input  word_t            w_i,
  output work_t            st_o
);
  word_t f_val;
  word_t k_val;
  word_t t_val;

  always_comb begin
    if (round_i < CNT_W'(STAGE)) begin
      f_val = (st_i.b & st_i.c) | (~st_i.b & st_i.d);
      k_val = 32'h5A827999;
    end else if (round_i < CNT_W'(2*STAGE)) begin
      f_val = st_i.b ^ st_i.c ^ st_i.d;
      k_val = 32'h6ED9EBA1;
    end else if (round_i < CNT_W'(3*STAGE)) begin
      f_val = (st_i.b & st_i.c) | (st_i.b & st_i.d) | (st_i.c & st_i.d);
      k_val = 32'h8F1BBCDC;
    end else begin
      f_val = st_i.b ^ st_i.c ^ st_i.d;
      k_val = 32'hCA62C1D6;
    end
    t_val   = rotl(st_i.a, 5) + f_val + st_i.e + k_val + w_i;
    st_o.a  = t_val;
    st_o.b  = st_i.a;
    st_o.c  = rotl(st_i.b, 30);
    st_o.d  = st_i.c;
    st_o.e  = st_i.d;
  end
endmodule

// File: rtl/sha1_ctrl.sv
module sha1_ctrl
  import sha1_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             next_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             start_o,
  output logic             load_work_o,
  output logic             adv_o,
  output logic             fin_o,
  output logic [CNT_W-1:0] round_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  assign ready_o     = (state_q == ST_IDLE);
  assign accept_o    = ready_o && (init_i || next_i);
  assign start_o     = ready_o && init_i;  // start wins over continue
  assign load_work_o = (state_q == ST_SETUP);
  assign adv_o       = (state_q == ST_ROUND);
  assign fin_o       = (state_q == ST_FINAL);
  assign round_o     = cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = ST_SETUP;
      ST_SETUP: state_d = ST_ROUND;
      ST_ROUND: if (cnt_q == LAST) state_d = ST_FINAL;
      ST_FINAL: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_work_o)  cnt_q <= '0;
      else if (adv_o)   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sha1_engine.sv
module sha1_engine
  import sha1_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic                next_i,
  input  logic [BLOCK_W-1:0]  block_i,
  output logic                ready_o,
  output logic [DIGEST_W-1:0] digest_o,
  output logic                digest_valid_o
);
  logic             accept, start, load_work, w_adv, fin;
  logic [CNT_W-1:0] round;
  word_t            w_cur;
  work_t            h_q, work_q, work_nxt;
  logic             valid_q;

  sha1_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .next_i      (next_i),
    .ready_o     (ready_o),
    .accept_o    (accept),
    .start_o     (start),
    .load_work_o (load_work),
    .adv_o       (w_adv),
    .fin_o       (fin),
    .round_o     (round)
  );

  sha1_wsched u_wsched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .adv_i   (w_adv),
    .block_i (block_i),
    .w_o     (w_cur)
  );

  sha1_round u_round (
    .round_i (round),
    .st_i    (work_q),
    .w_i     (w_cur),
    .st_o    (work_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    h_q <= '0;
    else if (start) h_q <= IV;
    else if (fin)   h_q <= add_work(h_q, work_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        work_q <= '0;
    else if (load_work) work_q <= h_q;
    else if (w_adv)     work_q <= work_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     valid_q <= 1'b0;
    else if (accept) valid_q <= 1'b0;
    else if (fin)    valid_q <= 1'b1;
  end

  assign digest_o       = h_q;
  assign digest_valid_o = valid_q;
endmodule

// File: rtl/sha1_engine_chk.sv
module sha1_engine_chk
  import sha1_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                init_i,
  input logic                next_i,
  input logic                ready_o,
  input logic                digest_valid_o,
  input logic [DIGEST_W-1:0] digest_o,
  input logic                w_adv
);
  logic [6:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              busy_cnt <= '0;
    else if (ready_o && (init_i || next_i))   busy_cnt <= '0;
    else if (!ready_o && busy_cnt != 7'h7f)   busy_cnt <= busy_cnt + 7'd1;
  end

  assert_accept_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && (init_i || next_i)) |=> (!ready_o && !digest_valid_o));

  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (busy_cnt == 7'd82));

  assert_adv_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_adv |-> !ready_o);

  assert_digest_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> $stable(digest_o));

  assert_valid_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digest_valid_o |-> ready_o);

  assert_valid_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digest_valid_o && !init_i && !next_i) |=> digest_valid_o);
endmodule

bind sha1_engine sha1_engine_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .init_i         (init_i),
  .next_i         (next_i),
  .ready_o        (ready_o),
  .digest_valid_o (digest_valid_o),
  .digest_o       (digest_o),
  .w_adv          (w_adv)
);

// File: tb/sim_sha1_engine.sv
module sim_sha1_engine;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         init_i = 1'b0;
  logic         next_i = 1'b0;
  logic [511:0] block_i = '0;
  logic         ready_o;
  logic [159:0] digest_o;
  logic         digest_valid_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [159:0] h_model = '0;
  logic [159:0] exp_q[$];
  int           acc_q[$];
  string        tag_q[$];
  logic         rdy_prev = 1'b1;

  localparam logic [159:0] IV_W = 160'h67452301EFCDAB8998BADCFE10325476C3D2E1F0;

  sha1_engine u0 (.*);

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_compress(input logic [159:0] h, input logic [511:0] blk);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    {a, b, c, d, e} = h;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
  endfunction

  function automatic logic [511:0] rand_block();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: predicts acceptance from ready_o, pushes expected digest
  task automatic issue(input bit ini, input bit nxt, input logic [511:0] blk, input string tag);
    logic [159:0] held;
    bit           acc;
    @(negedge clk_i);
    init_i  = ini;
    next_i  = nxt;
    block_i = blk;
    held    = digest_o;
    acc     = ready_o && (ini || nxt);
    if (acc) begin
      h_model = ini ? ref_compress(IV_W, blk) : ref_compress(h_model, blk);
      exp_q.push_back(h_model);
      acc_q.push_back(cyc);
      tag_q.push_back(tag);
    end
    @(negedge clk_i);
    init_i  = 1'b0;
    next_i  = 1'b0;
    block_i = rand_block();  // R8: post-capture change must not matter
    if (acc) begin
      check(!ready_o && !digest_valid_o, "R5", {158'd0, ready_o, digest_valid_o}, '0);
    end else begin
      check(digest_o == held, "R6", digest_o, held);
    end
  endtask

  task automatic wait_done();
    do @(negedge clk_i); while (exp_q.size() != 0 || !ready_o);
  endtask

  // monitor: pops expected result when ready rises
  always @(negedge clk_i) begin
    if (rst_ni && ready_o && !rdy_prev) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", digest_o, '0);
      end else begin
        logic [159:0] e;
        int           a;
        string        t;
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        t = tag_q.pop_front();
        check(digest_o == e, t, digest_o, e);
        // accept edge is cyc(a)+1; ready rises 82 edges later
        check(cyc - a == 83, "R4", 160'(cyc - a), 160'd83);
        check(digest_valid_o, "R9", {159'd0, digest_valid_o}, 160'd1);
      end
    end
    rdy_prev = ready_o;
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [511:0] b_abc, b_m1, b_m2, b_tmp;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check(ready_o && !digest_valid_o && digest_o == '0, "R1", digest_o, '0);

    // R3: continue directly from reset chains from zero
    issue(1'b0, 1'b1, rand_block(), "R3");
    wait_done();

    // R2/R10: single-block "abc" with known digest
    b_abc = {32'h61626380, 416'd0, 64'd24};
    issue(1'b1, 1'b0, b_abc, "R2");
    wait_done();
    check(digest_o == 160'ha9993e364706816aba3e25717850c26c9cd0d89d, "R10",
          digest_o, 160'ha9993e364706816aba3e25717850c26c9cd0d89d);

    // R9: valid holds while idle
    repeat (5) @(negedge clk_i);
    check(digest_valid_o && ready_o, "R9", {158'd0, digest_valid_o, ready_o}, 160'd3);

    // R3: two-block message with known digest
    b_m1 = {"abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq", 8'h80, 56'd0};
    b_m2 = {448'd0, 64'd448};
    issue(1'b1, 1'b0, b_m1, "R2");
    wait_done();
    issue(1'b0, 1'b1, b_m2, "R3");
    wait_done();
    check(digest_o == 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1, "R3",
          digest_o, 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1);

    // R7: both strobes -> start wins
    issue(1'b1, 1'b1, rand_block(), "R7");
    wait_done();

    // R6: strobes during busy are ignored
    issue(1'b0, 1'b1, rand_block(), "R6");
    repeat (10) @(negedge clk_i);
    issue(1'b1, 1'b0, rand_block(), "R6");
    repeat (40) @(negedge clk_i);
    issue(1'b0, 1'b1, rand_block(), "R6");
    wait_done();

    // R3/R8: long random chain, back-to-back
    for (int i = 0; i < 6; i++) begin
      issue(i == 0, i != 0, rand_block(), "R3");
      wait_done();
    end

    // R8: command issued right as previous result lands
    issue(1'b1, 1'b0, rand_block(), "R8");
    wait_done();
    issue(1'b0, 1'b1, rand_block(), "R8");
    wait_done();

    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R4", 160'(exp_q.size()), '0);
    finish_run();
  end
endmodule